// File: doc/BRIEF.md
# Delta Fibonacci Sample Compressor

This block losslessly shrinks a stream of 12-bit ADC samples that arrive interleaved from many channels. For every accepted sample it forms the signed difference from the last sample seen on the same channel. It folds that difference into a positive integer and encodes the integer with a Fibonacci (Zeckendorf) universal code, so quiet channels whose samples barely move produce two- to five-bit codewords. It concatenates the codewords into a bit stream and hands that stream out as fixed-width words over a valid/ready interface.

Codewords for small integers come from a registered lookup table. Integers beyond the table depth are encoded by arithmetic logic that yields the same code. A flush request drains the pipeline, zero-pads whatever partial word remains and emits it, so a capture can be closed at any sample boundary. Because every codeword ends in two consecutive ones and no codeword contains that pair anywhere else, a receiver can split the stream without length fields.

Top module: `delta_fib_compressor`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Each sample is encoded as its difference from the previous accepted sample of the same channel. The first sample of a channel after reset is taken relative to 0. Channels do not affect one another.
- R3: A difference d is mapped to the integer N = 2d+1 when d >= 0 and to N = -2d when d < 0 (0 gives 1, -1 gives 2, +1 gives 3).
- R4: The codeword for N is its Zeckendorf representation over the weights 1, 2, 3, 5, 8, ... with the weight 1 term first, followed by one extra 1 bit. Every codeword therefore ends in "11". Example: N=3 gives bits 0,0,1,1 and N=2 gives 0,1,1.
- R5: Codewords are packed back to back, with the first stream bit in bit 0 of an output word. A 32-bit word is emitted whenever at least 32 bits are pending.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. When the packer has no room, `in_ready` drops and no sample is lost.
- R7: A pulse on `flush` drains accepted samples, then emits the remaining partial word with zero padding above the last stream bit. `in_ready` is low until this completes. A flush with nothing pending emits no word.
- R8: A decoder that applies R4, R3 and R2 in reverse recovers every sample exactly, including full-scale steps of 0 to 4095 and back.
- R9: On a stream whose successive differences lie within plus or minus 2, the output is at most half the size of the raw 12-bit samples.
- R10: Integers below the table depth take their codeword from the table. Larger integers take it from the arithmetic encoder, and both paths give the R4 code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_channel | input | CH_W (6) | Channel index of the sample |
| in_sample | input | SAMPLE_W (12) | Unsigned ADC sample |
| flush | input | 1 | Pulse: emit the pending partial word once drained |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | WORD_W (32) | Packed codeword bits, earliest bit in bit 0 |

## Verification
The bench builds the block with 4 channels, 12-bit samples, 32-bit words and a 64-entry codeword table. The small channel count lets a few samples interleave every channel and revisit each one many times. The shallow table pushes ordinary ramp and full-scale steps past the table limit, so both the table and the arithmetic encoder are exercised against the same expected bit stream. Random stalls on `out_ready` keep the accumulator near full, so the input stall path and the word-hold behaviour are reached in a short run.

// File: rtl/fibz_pkg.sv
package fibz_pkg;

    // Number of Fibonacci weights considered; enough for integers below 1.3M.
    localparam int FIB_TERMS = 30;

    // Codeword bits: Zeckendorf pattern, weight 1 in bit 0, then a closing 1.
    function automatic logic [31:0] fib_code_bits(input int value);
        int          terms [FIB_TERMS];
        int          rem;
        int          top;
        logic [31:0] bits;
        terms[0] = 1;
        terms[1] = 2;
        for (int i = 2; i < FIB_TERMS; i++) terms[i] = terms[i-1] + terms[i-2];
        bits = '0;
        rem  = value;
        top  = -1;
        for (int i = FIB_TERMS - 1; i >= 0; i--) begin
            if (terms[i] <= rem) begin
                bits[i] = 1'b1;
                rem     = rem - terms[i];
                if (top < 0) top = i;
            end
        end
        if (top >= 0) bits[top+1] = 1'b1;
        return bits;
    endfunction

    // Codeword length including the closing 1; 0 for values below 1.
    function automatic int fib_code_len(input int value);
        int terms [FIB_TERMS];
        int rem;
        int top;
        terms[0] = 1;
        terms[1] = 2;
        for (int i = 2; i < FIB_TERMS; i++) terms[i] = terms[i-1] + terms[i-2];
        rem = value;
        top = -1;
        for (int i = FIB_TERMS - 1; i >= 0; i--) begin
            if (terms[i] <= rem) begin
                rem = rem - terms[i];
                if (top < 0) top = i;
            end
        end
        return (top >= 0) ? top + 2 : 0;
    endfunction

endpackage

// File: rtl/fibz_delta_stage.sv
module fibz_delta_stage #(
    parameter int CHANNELS = 64,
    parameter int SAMPLE_W = 12,
    parameter int CH_W     = 6,
    parameter int N_W      = SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                accept,
    input  logic [CH_W-1:0]     ch,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                s1_valid,
    output logic [N_W-1:0]      s1_n
);

    typedef struct packed {
        logic           valid;
        logic [N_W-1:0] n;
    } s1_t;

    s1_t                s1_d, s1_q;
    logic [SAMPLE_W-1:0] prev_d [CHANNELS];
    logic [SAMPLE_W-1:0] prev_q [CHANNELS];
    logic [SAMPLE_W:0]   delta;
    logic [SAMPLE_W:0]   delta_neg;
    logic [N_W-1:0]      n_calc;

    always_comb begin
        // R2: difference from this channel's last sample
        delta     = {1'b0, sample} - {1'b0, prev_q[ch]};
        delta_neg = ~delta + 1'b1;
        // R3: fold sign into a positive integer
        if (delta[SAMPLE_W]) n_calc = {delta_neg[SAMPLE_W-1:0], 1'b0};
        else                 n_calc = {delta[SAMPLE_W-1:0], 1'b1};

        prev_d = prev_q;
        if (accept) prev_d[ch] = sample;

        s1_d = s1_q;
        if (adv) begin
            s1_d.valid = accept;
            s1_d.n     = n_calc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            for (int i = 0; i < CHANNELS; i++) prev_q[i] <= '0;
        end else begin
            s1_q   <= s1_d;
            prev_q <= prev_d;
        end
    end

    assign s1_valid = s1_q.valid;
    assign s1_n     = s1_q.n;

    // R2: the channel's history holds the sample accepted one cycle earlier
    a_r2_prev_update: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> prev_q[$past(ch)] == $past(sample));

endmodule

// File: rtl/fibz_code_stage.sv
module fibz_code_stage #(
    parameter int N_W      = 13,
    parameter int TABLE_AW = 10,
    parameter int CODE_W   = 20,
    parameter int LEN_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              s1_valid,
    input  logic [N_W-1:0]    s1_n,
    output logic              code_valid,
    output logic [CODE_W-1:0] code_bits,
    output logic [LEN_W-1:0]  code_len
);
    import fibz_pkg::*;

    localparam int TABLE_DEPTH = 2 ** TABLE_AW;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
    } s2_t;

    s2_t               s2_d, s2_q;
    logic [CODE_W-1:0] tbl_code [TABLE_DEPTH];
    logic [LEN_W-1:0]  tbl_len  [TABLE_DEPTH];
    logic              in_table;
    logic [CODE_W-1:0] calc_code;
    logic [LEN_W-1:0]  calc_len;

    // R10: codeword table filled from the code definition
    for (genvar g = 0; g < TABLE_DEPTH; g++) begin : g_tbl
        assign tbl_code[g] = CODE_W'(fib_code_bits(g));
        assign tbl_len[g]  = LEN_W'(fib_code_len(g));
    end

    always_comb begin
        in_table  = (s1_n >> TABLE_AW) == '0;
        calc_code = CODE_W'(fib_code_bits(int'(s1_n)));
        calc_len  = LEN_W'(fib_code_len(int'(s1_n)));

        s2_d = s2_q;
        if (adv) begin
            s2_d.valid = s1_valid;
            if (in_table) begin
                s2_d.code = tbl_code[s1_n[TABLE_AW-1:0]];
                s2_d.len  = tbl_len[s1_n[TABLE_AW-1:0]];
            end else begin
                s2_d.code = calc_code;
                s2_d.len  = calc_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign code_valid = s2_q.valid;
    assign code_bits  = s2_q.code;
    assign code_len   = s2_q.len;

    // R4: every delivered codeword closes with two ones
    a_r4_terminator: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (code_len >= LEN_W'(2)) && code_bits[code_len-1] && code_bits[code_len-2]);

endmodule

// File: rtl/fibz_bit_packer.sv
module fibz_bit_packer #(
    parameter int WORD_W = 32,
    parameter int CODE_W = 20,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_bits,
    input  logic [LEN_W-1:0]  code_len,
    input  logic              pipe_busy,
    input  logic              flush,
    output logic              adv,
    output logic              flush_pend,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    localparam int ACC_W = WORD_W + CODE_W;
    localparam int CNT_W = $clog2(ACC_W + 1);

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic              flush_pend;
        logic              out_valid;
        logic [WORD_W-1:0] out_data;
    } pk_t;

    pk_t              pk_d, pk_q;
    logic             out_free;
    logic             pipe_idle;
    logic             pop_full;
    logic             pop_flush;
    logic             room;
    logic [ACC_W-1:0] acc_s;
    logic [CNT_W-1:0] cnt_s;

    always_comb begin
        pk_d      = pk_q;
        out_free  = !pk_q.out_valid || out_ready;
        pipe_idle = !pipe_busy && !code_valid;
        if (pk_q.out_valid && out_ready) pk_d.out_valid = 1'b0;

        pop_full  = out_free && (pk_q.cnt >= CNT_W'(WORD_W));
        pop_flush = out_free && pk_q.flush_pend && pipe_idle &&
                    (pk_q.cnt != '0) && (pk_q.cnt < CNT_W'(WORD_W));

        acc_s = pk_q.acc;
        cnt_s = pk_q.cnt;
        if (pop_full || pop_flush) begin
            pk_d.out_valid = 1'b1;
            pk_d.out_data  = pk_q.acc[WORD_W-1:0];
            acc_s          = pk_q.acc >> WORD_W;
            cnt_s          = pop_full ? pk_q.cnt - CNT_W'(WORD_W) : '0;
        end

        room = ({1'b0, cnt_s} + (CNT_W+1)'(code_len)) <= (CNT_W+1)'(ACC_W);
        if (code_valid && room) begin
            acc_s = acc_s | (ACC_W'(code_bits) << cnt_s);
            cnt_s = cnt_s + CNT_W'(code_len);
        end
        pk_d.acc = acc_s;
        pk_d.cnt = cnt_s;

        if (pk_q.flush_pend && pipe_idle && ((pk_q.cnt == '0) || pop_flush))
            pk_d.flush_pend = 1'b0;
        if (flush) pk_d.flush_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign adv        = !code_valid || room;
    assign flush_pend = pk_q.flush_pend;
    assign out_valid  = pk_q.out_valid;
    assign out_data   = pk_q.out_data;

    // R5: pending bit count never exceeds the accumulator
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.cnt <= CNT_W'(ACC_W));

    // R6: a refused word stays put
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: bits above the last stream bit of a flushed word are zero
    a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pop_flush |=> ((out_data >> $past(pk_q.cnt)) == '0));

endmodule

// File: rtl/delta_fib_compressor.sv
module delta_fib_compressor #(
    parameter int CHANNELS = 64,
    parameter int SAMPLE_W = 12,
    parameter int WORD_W   = 32,
    parameter int TABLE_AW = 10,
    localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CH_W-1:0]     in_channel,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                flush,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data
);

    localparam int N_W    = SAMPLE_W + 1;
    localparam int CODE_W = fibz_pkg::fib_code_len(2 ** N_W - 1);
    localparam int LEN_W  = $clog2(CODE_W + 1);

    logic              adv;
    logic              accept;
    logic              flush_pend;
    logic              s1_valid;
    logic [N_W-1:0]    s1_n;
    logic              code_valid;
    logic [CODE_W-1:0] code_bits;
    logic [LEN_W-1:0]  code_len;

    assign in_ready = adv && !flush_pend;
    assign accept   = in_valid && in_ready;

    fibz_delta_stage #(
        .CHANNELS (CHANNELS),
        .SAMPLE_W (SAMPLE_W),
        .CH_W     (CH_W),
        .N_W      (N_W)
    ) i_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .accept   (accept),
        .ch       (in_channel),
        .sample   (in_sample),
        .s1_valid (s1_valid),
        .s1_n     (s1_n)
    );

    fibz_code_stage #(
        .N_W      (N_W),
        .TABLE_AW (TABLE_AW),
        .CODE_W   (CODE_W),
        .LEN_W    (LEN_W)
    ) i_code (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .s1_valid   (s1_valid),
        .s1_n       (s1_n),
        .code_valid (code_valid),
        .code_bits  (code_bits),
        .code_len   (code_len)
    );

    fibz_bit_packer #(
        .WORD_W (WORD_W),
        .CODE_W (CODE_W),
        .LEN_W  (LEN_W)
    ) i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_valid (code_valid),
        .code_bits  (code_bits),
        .code_len   (code_len),
        .pipe_busy  (s1_valid),
        .flush      (flush),
        .adv        (adv),
        .flush_pend (flush_pend),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    // R6: samples are refused, not dropped, while the packer is full
    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !adv) |=> code_valid && $stable(code_bits));

endmodule

// File: tb/test_delta_fib_compressor.sv
`timescale 1ns/100ps
module test_delta_fib_compressor;

    localparam int CHANNELS = 4;
    localparam int SAMPLE_W = 12;
    localparam int WORD_W   = 32;
    localparam int TABLE_AW = 6;
    localparam int CH_W     = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [CH_W-1:0]     in_channel = '0;
    logic [SAMPLE_W-1:0] in_sample = '0;
    logic                flush = 1'b0;
    logic                out_valid;
    logic                out_ready = 1'b1;
    logic [WORD_W-1:0]   out_data;

    delta_fib_compressor #(
        .CHANNELS (CHANNELS),
        .SAMPLE_W (SAMPLE_W),
        .WORD_W   (WORD_W),
        .TABLE_AW (TABLE_AW)
    ) i_delta_fib_compressor (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_channel (in_channel),
        .in_sample  (in_sample),
        .flush      (flush),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    always #2 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    int          fibv [32];
    bit          expb [$];
    logic [31:0] rx [$];
    int          sent_ch [$];
    int          sent_val [$];
    int          prev_m [CHANNELS];
    int          stall_mode = 0;
    int          stall_cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    // ready driver: changes just after a rising edge
    always @(posedge clk) begin
        #0.5;
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (stall_mode == 0) ? 1'b1 : (lfsr[0] & lfsr[3]);
    end

    // collector: sample mid-cycle
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) rx.push_back(out_data);
        if (rst_n && in_valid && !in_ready) stall_cycles++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_push(input int ch, input int val);
        int d, n, rem, top;
        bit bits [32];
        d = val - prev_m[ch];
        prev_m[ch] = val;
        n = (d >= 0) ? 2 * d + 1 : -2 * d;
        rem = n;
        top = 0;
        for (int i = 0; i < 32; i++) bits[i] = 1'b0;
        for (int i = 25; i >= 0; i--) begin
            if (fibv[i] <= rem) begin
                if (top == 0 && !bits[i+1]) top = i;
                bits[i] = 1'b1;
                rem -= fibv[i];
            end
        end
        for (int i = 0; i <= top; i++) expb.push_back(bits[i]);
        expb.push_back(1'b1);
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; flush = 1'b0;
        repeat (3) @(negedge clk);
        expb.delete(); rx.delete(); sent_ch.delete(); sent_val.delete();
        for (int c = 0; c < CHANNELS; c++) prev_m[c] = 0;
        stall_cycles = 0;
        rst_n = 1'b1;
    endtask

    task automatic send(input int ch, input int val);
        model_push(ch, val);
        sent_ch.push_back(ch);
        sent_val.push_back(val);
        @(negedge clk);
        in_valid = 1'b1; in_channel = CH_W'(ch); in_sample = SAMPLE_W'(val);
        #0.5;
        while (!in_ready) begin
            @(negedge clk);
            #0.5;
        end
        @(posedge clk);
        #0.5 in_valid = 1'b0;
    endtask

    task automatic do_flush();
        while (expb.size() % WORD_W != 0) expb.push_back(1'b0);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        repeat (300) @(negedge clk);
    endtask

    task automatic compare_stream(input string tag);
        int nw;
        logic [31:0] w;
        nw = expb.size() / WORD_W;
        chk(rx.size() == nw, {tag, " word count"}, rx.size(), nw);
        for (int k = 0; k < nw && k < rx.size(); k++) begin
            for (int b = 0; b < WORD_W; b++) w[b] = expb[k*WORD_W + b];
            chk(rx[k] == w, {tag, " word"}, rx[k], w);
        end
    endtask

    // independent decompressor: split on "11", sum weights, unfold, accumulate
    task automatic decode_check(input string tag);
        int got, val, idx, n, d;
        int pm [CHANNELS];
        bit pb, b;
        int bad;
        for (int c = 0; c < CHANNELS; c++) pm[c] = 0;
        got = 0; val = 0; idx = 0; pb = 0; bad = 0;
        for (int k = 0; k < rx.size() && got < sent_val.size(); k++) begin
            for (int j = 0; j < WORD_W && got < sent_val.size(); j++) begin
                b = rx[k][j];
                if (b && pb) begin
                    n = val;
                    d = (n % 2 == 1) ? (n - 1) / 2 : -(n / 2);
                    pm[sent_ch[got]] += d;
                    if (pm[sent_ch[got]] != sent_val[got]) begin
                        bad++;
                        chk(0, {tag, " sample"}, pm[sent_ch[got]], sent_val[got]);
                    end
                    got++; val = 0; idx = 0; pb = 0;
                end else begin
                    if (b) val += fibv[idx];
                    idx++;
                    pb = b;
                end
            end
        end
        chk(got == sent_val.size(), {tag, " decoded count"}, got, sent_val.size());
        chk(bad == 0, {tag, " mismatching samples"}, bad, 0);
    endtask

    task automatic test_reset();
        reset_dut();
        #0.5;
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    endtask

    task automatic test_known_codes();
        reset_dut();
        send(1, 1);   // R3 d=+1 -> N=3, R4 bits 0011
        send(1, 0);   // R3 d=-1 -> N=2, R4 bits 011
        do_flush();
        chk(rx.size() == 1, "R7 flushed word count", rx.size(), 1);
        if (rx.size() > 0)
            chk(rx[0] == 32'h0000_006C, "R4 hand-coded word", rx[0], 32'h6C);
    endtask

    task automatic test_zero_run();
        reset_dut();
        for (int i = 0; i < 64; i++) send(i % CHANNELS, 0);
        repeat (20) @(negedge clk);
        chk(rx.size() == 4, "R5 words from 128 bits", rx.size(), 4);
        for (int k = 0; k < rx.size(); k++)
            chk(rx[k] == 32'hFFFF_FFFF, "R5 all-zero-delta word", rx[k], 32'hFFFF_FFFF);
        do_flush();
        chk(rx.size() == 4, "R7 flush on word boundary adds nothing", rx.size(), 4);
    endtask

    task automatic test_interleave();
        reset_dut();
        for (int i = 0; i < 120; i++) send(i % CHANNELS, (100 * (i % CHANNELS) + 3 * (i / CHANNELS)) % 4096);
        do_flush();
        compare_stream("R2 interleaved ramps");
        decode_check("R2 interleaved ramps");
    endtask

    task automatic test_extremes();
        reset_dut();
        for (int i = 0; i < 24; i++) send(2, (i % 2 == 0) ? 4095 : 0);
        send(3, 31); send(3, 0); send(3, 32); send(3, 0);   // R10 N=63 table, N=64/65 computed
        do_flush();
        compare_stream("R10 table and computed paths");
        decode_check("R8 full-scale steps");
    endtask

    task automatic test_backpressure();
        reset_dut();
        stall_mode = 1;
        for (int i = 0; i < 200; i++) send(i % CHANNELS, 1000 + 700 * (i % CHANNELS) + (lfsr[2:0] ^ 3'(i)));
        do_flush();
        stall_mode = 0;
        repeat (5) @(negedge clk);
        compare_stream("R6 random stalls");
        decode_check("R8 under stalls");
        chk(stall_cycles > 0, "R6 in_ready dropped under stall", stall_cycles, 1);
    endtask

    task automatic test_ratio();
        int noise;
        reset_dut();
        for (int i = 0; i < 256; i++) begin
            noise = int'(lfsr[1:0] % 3) - 1;
            send(i % CHANNELS, 2000 + noise);
            @(negedge clk);
        end
        do_flush();
        compare_stream("R9 quiet noise");
        chk(rx.size() * WORD_W * 2 <= 256 * SAMPLE_W, "R9 ratio of at least 2", rx.size() * WORD_W, 256 * SAMPLE_W / 2);
    endtask

    task automatic test_flush_empty();
        reset_dut();
        do_flush();
        chk(rx.size() == 0, "R7 flush with nothing pending", rx.size(), 0);
        send(0, 5);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        #0.5;
        chk(in_ready == 1'b0, "R7 in_ready low during flush", in_ready, 0);
        while (expb.size() % WORD_W != 0) expb.push_back(1'b0);
        repeat (50) @(negedge clk);
        compare_stream("R7 single-sample flush");
    endtask

    initial begin
        fibv[0] = 1; fibv[1] = 2;
        for (int i = 2; i < 32; i++) fibv[i] = fibv[i-1] + fibv[i-2];
        test_reset();
        test_known_codes();
        test_zero_run();
        test_interleave();
        test_extremes();
        test_backpressure();
        test_ratio();
        test_flush_empty();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule